// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a register-mapped general-purpose I/O controller for a pin count that is a multiple of 32. The default is 64 pins. Pins are grouped into 32-bit banks. A host reads and writes it through a simple single-cycle request port. It drives each pad's output value and output enable, and it samples each pad's input through a two-flop synchroniser. Software can read back pin levels and program pin direction. Output values change only through separate write-one-to-set and write-one-to-clear words, so one pin can be changed without a read-modify-write.

Each pin can capture a rising edge, a falling edge or both into a sticky status bit. Software clears a status bit by writing a 1 to it. A single active-high interrupt is raised while any status bit is set.

Registers are grouped by feature. Each feature occupies BANKS consecutive 32-bit words, one per bank, so the distance between features grows with the pin count.

The host port is run by a two-state machine:
- BUS_IDLE: no read data is pending.
- BUS_RESP: read data is presented for one cycle.

Its transitions are:
- RD_ACCEPT: from either state to BUS_RESP, on a read request.
- RD_DONE: from either state to BUS_IDLE, when no read is requested.

Writes take effect in the cycle they are accepted, in either state.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: The word index is the byte address divided by 4. Kind k, bank b sits at byte address k×BANKS×4 + b×4, and bit i of that word is pin b×32+i. The kinds in order are: 0 level, 1 direction, 2 set, 3 clear, 4 rise enable, 5 fall enable, 6 status. With 64 pins these words start at 0x00, 0x08, 0x10, 0x18, 0x20, 0x28 and 0x30.
- R2: The direction word is read/write and reads back its stored value. A direction bit of 1 drives the matching `pad_oe` bit high, making the pin an output.
- R3: Writing the set word drives high every `pad_out` bit whose data bit is 1. Bits written as 0 keep their value.
- R4: Writing the clear word drives low every `pad_out` bit whose data bit is 1. Bits written as 0 keep their value.
- R5: The level word returns `pad_in` after two synchroniser flops. A read accepted at the first or second rising edge after a pad change returns the old value, and a read accepted at the third returns the new value.
- R6: A 0→1 change of a synchronised pin whose rise enable is 1 sets that pin's status bit. Pins without the enable are not captured.
- R7: A 1→0 change of a synchronised pin whose fall enable is 1 sets its status bit. With both enables set, either change is captured.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it set.
- R9: If a clear write and a newly detected edge meet on the same status bit in the same cycle, the bit stays set.
- R10: `irq` is high exactly while any status bit in any bank is set.
- R11: The set and clear words read as 0. Writes to the level word have no effect. Accesses at or beyond word index 7×BANKS, or with a nonzero `bus_addr[1:0]`, are ignored and read as 0.
- R12: After reset every register is 0: all pins are inputs, `pad_out` is 0, no edge enable is set and `irq` is low.
- R13: A read accepted at a rising edge presents `bus_rdata` with `bus_rvalid` high for the following cycle. `bus_rvalid` is low after any cycle with no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| irq | output | 1 | Combined edge interrupt, active high |

## Verification
Results become visible at fixed latencies after their stimulus:
- Writes reach `pad_out` and `pad_oe` right after the rising edge that accepts them.
- Read data appears right after the accepting edge and stays for one cycle.
- A pad change reaches the level word at the third edge.
- A pad change sets a status bit, and therefore `irq`, at the third edge.

The bench drives all inputs at falling edges and samples at falling edges. Its scoreboard pushes each read's expected word when the request is issued and pops it at the next falling edge with `bus_rvalid` high. The clear-versus-edge collision is hit by issuing the clear write two falling edges after the pad change, so that the edge that accepts the write is the one that captures the edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int BANK_W     = 32;
    localparam int KIND_COUNT = 7;

    typedef enum logic [2:0] {
        K_LEVEL = 3'd0,
        K_DIR   = 3'd1,
        K_SET   = 3'd2,
        K_CLR   = 3'd3,
        K_RISE  = 3'd4,
        K_FALL  = 3'd5,
        K_STAT  = 3'd6
    } reg_kind_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BANKS  = 2,
    localparam int BIDX_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output reg_kind_e         kind,
    output logic [BIDX_W-1:0] bank
);
    logic [ADDR_W-3:0] widx;
    assign widx = addr[ADDR_W-1:2];

    always_comb begin
        hit  = 1'b0;
        kind = K_LEVEL;
        bank = '0;
        for (int k = 0; k < KIND_COUNT; k++) begin
            if ((widx >= k * BANKS) && (widx < (k + 1) * BANKS)) begin
                hit  = (addr[1:0] == 2'b00);
                kind = reg_kind_e'(3'(k));
                bank = BIDX_W'(widx - k * BANKS);
            end
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  reg_kind_e         kind,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] level,
    output logic [BANK_W-1:0] out_o,
    output logic [BANK_W-1:0] dir_o,
    output logic [BANK_W-1:0] rise_o,
    output logic [BANK_W-1:0] fall_o,
    output logic [BANK_W-1:0] stat_o,
    output logic [BANK_W-1:0] det_o
);
    logic [BANK_W-1:0] out_q, dir_q, rise_q, fall_q, stat_q, prev_q;
    logic [BANK_W-1:0] set_w, clr_w, ack_w, det;
    logic              wr, dir_wr, rise_wr, fall_wr;

    assign wr      = sel && we;
    assign dir_wr  = wr && (kind == K_DIR);
    assign rise_wr = wr && (kind == K_RISE);
    assign fall_wr = wr && (kind == K_FALL);
    assign set_w   = (wr && (kind == K_SET))  ? wdata : '0;
    assign clr_w   = (wr && (kind == K_CLR))  ? wdata : '0;
    assign ack_w   = (wr && (kind == K_STAT)) ? wdata : '0;

    // Edge finder: synchronised level against its previous-cycle copy.
    assign det = (level & ~prev_q & rise_q) | (~level & prev_q & fall_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            stat_q <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= level;
            out_q  <= (out_q | set_w) & ~clr_w;
            if (dir_wr)  dir_q  <= wdata;
            if (rise_wr) rise_q <= wdata;
            if (fall_wr) fall_q <= wdata;
            // A fresh edge outranks a same-cycle acknowledge.
            stat_q <= (stat_q & ~ack_w) | det;
        end
    end

    assign out_o  = out_q;
    assign dir_o  = dir_q;
    assign rise_o = rise_q;
    assign fall_o = fall_q;
    assign stat_o = stat_q;
    assign det_o  = det;

    a_r3_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
        (set_w != '0) |=> (($past(set_w) & ~out_q) == '0));
    a_r4_clr_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w != '0) |=> (($past(clr_w) & out_q) == '0));
    a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(stat_q) & ~$past(ack_w) & ~stat_q) == '0));
    a_r9_edge_captured: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(det) & ~stat_q) == '0));
    a_r2_dir_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_wr |=> $stable(dir_q));
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    localparam int BANKS  = NUM_PINS / BANK_W;
    localparam int BIDX_W = (BANKS > 1) ? $clog2(BANKS) : 1;

    logic [NUM_PINS-1:0] lvl_all, stat_all, det_all;
    logic [BANK_W-1:0]   out_w [BANKS];
    logic [BANK_W-1:0]   dir_w [BANKS];
    logic [BANK_W-1:0]   rise_w[BANKS];
    logic [BANK_W-1:0]   fall_w[BANKS];
    logic [BANK_W-1:0]   stat_w[BANKS];

    logic              acc_hit, rd_fire;
    reg_kind_e         acc_kind;
    logic [BIDX_W-1:0] acc_bank;
    logic [31:0]       rd_word, rdata_q;
    bus_state_e        state_q, state_d;

    gpio_pin_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl_all)
    );

    gpio_addr_decode #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_dec (
        .addr(bus_addr), .hit(acc_hit), .kind(acc_kind), .bank(acc_bank)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic bsel;
        assign bsel = bus_req && acc_hit && (acc_bank == BIDX_W'(b));

        gpio_bank u_bank (
            .clk(clk), .rst_n(rst_n), .sel(bsel), .we(bus_we),
            .kind(acc_kind), .wdata(bus_wdata),
            .level(lvl_all[b*BANK_W +: BANK_W]),
            .out_o(out_w[b]), .dir_o(dir_w[b]),
            .rise_o(rise_w[b]), .fall_o(fall_w[b]),
            .stat_o(stat_w[b]),
            .det_o(det_all[b*BANK_W +: BANK_W])
        );

        assign pad_out[b*BANK_W +: BANK_W]  = out_w[b];
        assign pad_oe[b*BANK_W +: BANK_W]   = dir_w[b];
        assign stat_all[b*BANK_W +: BANK_W] = stat_w[b];
    end

    assign irq = |stat_all;

    always_comb begin
        rd_word = '0;
        if (acc_hit) begin
            unique case (acc_kind)
                K_LEVEL: rd_word = lvl_all[acc_bank*BANK_W +: BANK_W];
                K_DIR:   rd_word = dir_w[acc_bank];
                K_RISE:  rd_word = rise_w[acc_bank];
                K_FALL:  rd_word = fall_w[acc_bank];
                K_STAT:  rd_word = stat_w[acc_bank];
                default: rd_word = '0;
            endcase
        end
    end

    assign rd_fire = bus_req && !bus_we;

    // Host port state machine: RD_ACCEPT -> BUS_RESP, RD_DONE -> BUS_IDLE.
    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = rd_fire ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_fire ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_fire) rdata_q <= rd_word;
    end

    assign bus_rvalid = (state_q == BUS_RESP);
    assign bus_rdata  = rdata_q;

    a_r13_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> bus_rvalid);
    a_r13_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> !bus_rvalid);
    a_r10_irq_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(det_all != '0));
endmodule

// File: tb/gpio_banked_ctrl_tb_top.sv
module gpio_banked_ctrl_tb_top;
    localparam int NP = 64;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    gpio_banked_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops one expected word per valid read beat.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R13 unexpected rvalid", 64'(bus_rdata), 64'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                check(bus_rdata == e, t, 64'(bus_rdata), 64'(e));
            end
        end
    end

    initial begin
        #2_000_000;
        check(1'b0, "watchdog", 64'h0, 64'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R12 reset state
        check(pad_oe == '0 && pad_out == '0, "R12 pads after reset", pad_out | pad_oe, 64'h0);
        check(irq == 1'b0, "R12 irq after reset", 64'(irq), 64'h0);
        bus_read(8'h08, 32'h0, "R12 dir reset");
        bus_read(8'h20, 32'h0, "R12 rise enable reset");
        idle(1);
        check(bus_rvalid == 1'b0, "R13 rvalid drops when idle", 64'(bus_rvalid), 64'h0);

        // R2 / R1 direction per bank
        bus_write(8'h08, 32'hA5A5_0F0F);
        bus_write(8'h0C, 32'h1234_5678);
        check(pad_oe == 64'h1234_5678_A5A5_0F0F, "R2 R1 pad_oe banks", pad_oe, 64'h1234_5678_A5A5_0F0F);
        bus_read(8'h08, 32'hA5A5_0F0F, "R2 dir bank0 readback");
        bus_read(8'h0C, 32'h1234_5678, "R1 dir bank1 readback");

        // R3 set, R4 clear
        bus_write(8'h10, 32'h0000_00F0);
        check(pad_out == 64'h0000_00F0, "R3 set bank0", pad_out, 64'hF0);
        bus_write(8'h10, 32'h0000_000F);
        check(pad_out == 64'h0000_00FF, "R3 set keeps zeros", pad_out, 64'hFF);
        bus_write(8'h14, 32'h8000_0001);
        check(pad_out == 64'h8000_0001_0000_00FF, "R3 R1 set bank1", pad_out, 64'h8000_0001_0000_00FF);
        bus_write(8'h18, 32'h0000_003C);
        check(pad_out == 64'h8000_0001_0000_00C3, "R4 clear bank0", pad_out, 64'h8000_0001_0000_00C3);
        bus_write(8'h1C, 32'h8000_0000);
        check(pad_out == 64'h0000_0001_0000_00C3, "R4 clear bank1", pad_out, 64'h0000_0001_0000_00C3);

        // R11 ignored accesses
        bus_read(8'h10, 32'h0, "R11 set reads zero");
        bus_read(8'h1C, 32'h0, "R11 clear reads zero");
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h00, 32'h0, "R11 level write ignored");
        bus_write(8'h38, 32'hFFFF_FFFF);
        bus_write(8'h11, 32'hFFFF_FFFF);
        check(pad_out == 64'h0000_0001_0000_00C3 && pad_oe == 64'h1234_5678_A5A5_0F0F,
              "R11 out-of-range and unaligned writes ignored", pad_out, 64'h0000_0001_0000_00C3);
        bus_read(8'h38, 32'h0, "R11 out-of-range read");
        bus_read(8'hFC, 32'h0, "R11 top address read");
        bus_read(8'h09, 32'h0, "R11 unaligned read");

        // R5 synchroniser latency
        pad_in = 64'hDEAD_BEEF_0123_4567;
        bus_read(8'h00, 32'h0, "R5 level at first edge");
        bus_read(8'h00, 32'h0, "R5 level at second edge");
        bus_read(8'h00, 32'h0123_4567, "R5 level at third edge");
        bus_read(8'h04, 32'hDEAD_BEEF, "R5 R1 level bank1");
        check(irq == 1'b0, "R6 no capture without enables", 64'(irq), 64'h0);
        pad_in = '0;
        idle(4);

        // R6 rising edge, only enabled pin
        bus_write(8'h20, 32'h0000_0020);
        pad_in[5] = 1'b1; pad_in[6] = 1'b1;
        idle(2);
        check(irq == 1'b0, "R10 irq not before third edge", 64'(irq), 64'h0);
        idle(1);
        check(irq == 1'b1, "R10 irq at third edge", 64'(irq), 64'h1);
        bus_read(8'h30, 32'h0000_0020, "R6 rise captured only where enabled");

        // R8 acknowledge
        bus_write(8'h30, 32'h0);
        bus_read(8'h30, 32'h0000_0020, "R8 zero write keeps status");
        bus_write(8'h30, 32'h0000_0020);
        check(irq == 1'b0, "R10 irq clears with status", 64'(irq), 64'h0);
        bus_read(8'h30, 32'h0, "R8 one write clears status");

        // R7 both enables on bank1 pin 32
        bus_write(8'h24, 32'h1);
        bus_write(8'h2C, 32'h1);
        pad_in[32] = 1'b1;
        idle(4);
        bus_read(8'h34, 32'h1, "R7 rise with both enables");
        bus_write(8'h34, 32'h1);
        pad_in[32] = 1'b0;
        idle(4);
        check(irq == 1'b1, "R10 irq from bank1", 64'(irq), 64'h1);
        bus_read(8'h34, 32'h1, "R7 fall with both enables");
        bus_write(8'h34, 32'h1);
        bus_read(8'h34, 32'h0, "R8 bank1 cleared");

        // R7 fall only on bank0 pin 5, then R9 collision
        bus_write(8'h20, 32'h0);
        bus_write(8'h28, 32'h0000_0020);
        pad_in[5] = 1'b0;
        idle(4);
        bus_read(8'h30, 32'h0000_0020, "R7 fall captured");
        bus_write(8'h20, 32'h0000_0020);
        pad_in[5] = 1'b1;
        idle(2);
        bus_write(8'h30, 32'h0000_0020);
        bus_read(8'h30, 32'h0000_0020, "R9 edge wins over clear");
        bus_write(8'h30, 32'h0000_0020);
        bus_read(8'h30, 32'h0, "R9 later clear succeeds");
        idle(2);
        check(exp_q.size() == 0, "R13 every read answered", 64'(exp_q.size()), 64'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule